// File: doc/BRIEF.md
# Self-Starting Multi-Phase Clock Generator

This block turns one full-rate master clock into a set of staggered channel-select strobes for a time-interleaved sampler. A twisted-ring counter with half as many stages as there are phases divides the master clock. Each of its stages toggles with a 50% duty cycle at the master rate divided by the phase count. Two of these stages are ANDed to form a single strobe that is high for one master period in every rotation. A register chain then delays that strobe one master period per tap, which gives one select output per channel. Each select also serves as the start-of-conversion trigger for its channel.

The counter's contents are not assumed to start in a known pattern. Any pattern that lies outside the legal twisted-ring sequence is detected and replaced by the all-zero pattern on the next clock, so the block always returns to a correct rotation without outside help. A valid flag tells downstream logic when one complete rotation, first phase through last phase, has been emitted since reset or since the last recovery.

Top module: `phase_clock_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all `chan_sel` bits and `phases_valid` are 0 after that edge.
- R2: Once running, each `chan_sel` bit is high for exactly one master cycle in every NUM_PHASES cycles.
- R3: `chan_sel[i+1]` is high exactly one master cycle after `chan_sel[i]`, for i from 0 to NUM_PHASES-2. The rotation order is bit 0 first and the top bit last.
- R4: In every master cycle, at most one `chan_sel` bit is high.
- R5: With four stages, the legal divider patterns in sequence order are 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000. Any other pattern is replaced by 0000 on the next clock, and no strobe is emitted from it.
- R6: Let `k` be the sequence index of the pattern loaded at reset. Set j = (8-k) mod 8 for a legal pattern and j = 1 for an illegal one. Counting from the first rising edge with `rst_n` high as edge 1, `chan_sel[0]` first goes high after edge j+2.
- R7: `phases_valid` rises on the edge after the first `chan_sel[NUM_PHASES-1]` pulse that follows a `chan_sel[0]` pulse. It then stays high while no illegal divider pattern occurs.
- R8: The divider reloads the pattern RESET_STATE on every clock edge at which `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_master | input | 1 | Full-rate master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_sel | output | NUM_PHASES | One-period channel-select strobes, one per channel |
| phases_valid | output | 1 | High once a full rotation has been emitted |

## Verification
The assertions assume that the master clock runs freely and that `rst_n` changes only away from the rising edge. They also assume that any divider pattern other than the reset load can arise only from the recovery path. The bench meets these assumptions: it drives reset on falling edges and holds it low for several cycles. It covers every one of the sixteen possible starting patterns by building sixteen copies, each with a different reset load, instead of forcing internal state. A second reset in the middle of the run confirms that reload and recovery repeat identically.

// File: rtl/mpcg_pkg.sv
// Shared types for the multi-phase clock generator.
// Assumes nothing beyond standard SystemVerilog packages.
package mpcg_pkg;

    // Progress of the valid flag through one complete rotation
    typedef enum logic [1:0] {
        ROT_WAIT_FIRST = 2'd0,
        ROT_WAIT_LAST  = 2'd1,
        ROT_DONE       = 2'd2
    } rot_state_e;

endpackage

// File: rtl/mpcg_divider.sv
// Twisted-ring divider with illegal-state recovery and strobe gating.
// Each stage toggles at the clock rate divided by 2*STAGES with a 50% duty cycle.
// A legal pattern has at most one boundary between adjacent stages. Any other
// pattern is replaced by all-zero on the next edge. The strobe output is high
// for one cycle per rotation and is suppressed while the pattern is illegal.
// Assumes STAGES >= 2.
module mpcg_divider #(
    parameter int                STAGES      = 4,
    parameter logic [STAGES-1:0] RESET_STATE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] ring,
    output logic              legal,
    output logic              strobe
);

    localparam int BOUND_W = $clog2(STAGES) + 1;

    logic [BOUND_W-1:0] boundaries;

    // Count the boundaries between adjacent stages to classify the pattern
    always_comb begin
        boundaries = '0;
        for (int i = 0; i < STAGES - 1; i++) begin
            boundaries = boundaries + BOUND_W'(ring[i] ^ ring[i+1]);
        end
        legal = (boundaries <= BOUND_W'(1));
    end

    // Advance the twisted ring, or reload all-zero from an illegal pattern
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring <= RESET_STATE;
        end else if (!legal) begin
            ring <= '0;
        end else begin
            ring <= {ring[STAGES-2:0], ~ring[STAGES-1]};
        end
    end

    // AND two stage outputs into a one-in-a-rotation strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
        end else begin
            strobe <= legal & ~ring[STAGES-1] & ~ring[0];
        end
    end

    // R5: a legal pattern never leads to an illegal one
    assert_legal_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        legal |=> legal);

    // R5: an illegal pattern is followed by all-zero
    assert_illegal_recovers_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |=> (ring == '0));

    // R5: no strobe follows an illegal pattern
    assert_no_strobe_from_illegal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |=> !strobe);

endmodule

// File: rtl/mpcg_phase_chain.sv
// Delay chain that turns one strobe into NUM_PHASES staggered select strobes.
// Tap i carries the strobe delayed by i+1 cycles.
// Assumes the strobe is high at most once every NUM_PHASES cycles.
module mpcg_phase_chain #(
    parameter int NUM_PHASES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strobe,
    output logic [NUM_PHASES-1:0] phase
);

    // Shift the strobe one tap per master cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else begin
            phase <= {phase[NUM_PHASES-2:0], strobe};
        end
    end

    // R4: the taps never overlap
    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase));

    // R3: each tap passes to its successor one cycle later
    for (genvar gi = 1; gi < NUM_PHASES; gi++) begin : g_order
        assert_phase_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
            phase[gi-1] |=> phase[gi]);
    end

endmodule

// File: rtl/mpcg_lock.sv
// Valid-flag tracker. It raises the flag once the first phase and then the last
// phase have been seen, and it returns to waiting whenever a restart is signalled.
// Assumes the first and last phase strobes come from the same chain.
module mpcg_lock
    import mpcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic first_phase,
    input  logic last_phase,
    output logic locked
);

    rot_state_e state;

    // Follow one full rotation from the first tap to the last tap
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state <= ROT_WAIT_FIRST;
        end else begin
            case (state)
                ROT_WAIT_FIRST: if (first_phase) state <= ROT_WAIT_LAST;
                ROT_WAIT_LAST:  if (last_phase)  state <= ROT_DONE;
                ROT_DONE:       state <= ROT_DONE;
                default:        state <= ROT_WAIT_FIRST;
            endcase
        end
    end

    assign locked = (state == ROT_DONE);

    // R7: the flag rises only right after the last phase has been emitted
    assert_lock_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(last_phase));

    // R7: the flag stays high while no restart occurs
    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !restart) |=> locked);

endmodule

// File: rtl/phase_clock_gen.sv
// Top level of the self-starting multi-phase clock generator.
// It drives NUM_PHASES non-overlapping channel-select strobes, each one master
// period wide, in a fixed rotation. RESET_STATE is the divider pattern loaded
// during reset and may be any value, legal or not.
// Assumes NUM_PHASES is even and at least 4. Reset is synchronous and active-low.
module phase_clock_gen #(
    parameter int                        NUM_PHASES  = 8,
    parameter logic [NUM_PHASES/2-1:0]   RESET_STATE = '0
) (
    input  logic                  clk_master,
    input  logic                  rst_n,
    output logic [NUM_PHASES-1:0] chan_sel,
    output logic                  phases_valid
);

    localparam int STAGES = NUM_PHASES / 2;
    localparam int GAP_W  = $clog2(NUM_PHASES) + 1;

    logic [STAGES-1:0] ring;
    logic              ring_legal;
    logic              strobe;

    mpcg_divider #(
        .STAGES      (STAGES),
        .RESET_STATE (RESET_STATE)
    ) u_divider (
        .clk    (clk_master),
        .rst_n  (rst_n),
        .ring   (ring),
        .legal  (ring_legal),
        .strobe (strobe)
    );

    mpcg_phase_chain #(
        .NUM_PHASES (NUM_PHASES)
    ) u_chain (
        .clk    (clk_master),
        .rst_n  (rst_n),
        .strobe (strobe),
        .phase  (chan_sel)
    );

    mpcg_lock u_lock (
        .clk         (clk_master),
        .rst_n       (rst_n),
        .restart     (!ring_legal),
        .first_phase (chan_sel[0]),
        .last_phase  (chan_sel[NUM_PHASES-1]),
        .locked      (phases_valid)
    );

    // Checker state: cycles since the last first-phase strobe
    logic [GAP_W-1:0] gap_cnt;
    logic             gap_seen;

    // Measure the spacing between successive first-phase strobes
    always_ff @(posedge clk_master) begin
        if (!rst_n) begin
            gap_cnt  <= '0;
            gap_seen <= 1'b0;
        end else if (chan_sel[0]) begin
            gap_cnt  <= '0;
            gap_seen <= 1'b1;
        end else if (gap_cnt != {GAP_W{1'b1}}) begin
            gap_cnt  <= gap_cnt + 1'b1;
        end
    end

    // R2: first-phase strobes repeat every NUM_PHASES cycles
    assert_period_R2: assert property (@(posedge clk_master) disable iff (!rst_n)
        (chan_sel[0] && gap_seen) |-> (gap_cnt == GAP_W'(NUM_PHASES - 1)));

    // R2: a strobe lasts a single cycle
    assert_single_cycle_R2: assert property (@(posedge clk_master) disable iff (!rst_n)
        chan_sel[0] |=> !chan_sel[0]);

    // R8: the divider is loaded with RESET_STATE on an edge with reset low
    always_ff @(posedge clk_master) begin
        if (rst_n && !$past(rst_n)) begin
            assert_reset_load_R8: assert (ring == RESET_STATE);
        end
    end

endmodule

// File: tb/phase_clock_gen_bench.sv
// Scoreboard bench: sixteen copies, one for each possible reset load of the
// four-stage divider. A driver task pushes the per-cycle expected strobes and
// flags into a queue, and a monitor pops and compares them on falling edges.
module phase_clock_gen_bench;

    localparam int NPH   = 8;
    localparam int NSEED = 16;
    localparam int NCYC  = 40;

    typedef struct packed {
        logic [NSEED-1:0][NPH-1:0] sel;
        logic [NSEED-1:0]          lk;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_en = 1'b0;
    int   n_checks = 0;
    int   n_fails  = 0;
    int   cyc_no   = 0;

    exp_item_t exp_q[$];

    logic [NPH-1:0] sel_w [NSEED];
    logic           lk_w  [NSEED];

    always #2 clk = ~clk;

    for (genvar gi = 0; gi < NSEED; gi++) begin : g_seed
        phase_clock_gen #(
            .NUM_PHASES  (NPH),
            .RESET_STATE (4'(gi))
        ) u_phase_clock_gen (
            .clk_master   (clk),
            .rst_n        (rst_n),
            .chan_sel     (sel_w[gi]),
            .phases_valid (lk_w[gi])
        );
    end

    // Edge after which chan_sel[0] first goes high (R6), using the R5 sequence
    function automatic int first_edge(input int seed);
        logic [3:0] seq [8];
        int j;
        seq = '{4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111, 4'b1110, 4'b1100, 4'b1000};
        j = 1;
        for (int k = 0; k < 8; k++) begin
            if (seq[k] == 4'(seed)) j = (8 - k) % 8;
        end
        return j + 2;
    endfunction

    // Driver: push the expected outputs for edges 1..NCYC after reset release
    task automatic push_run();
        for (int n = 1; n <= NCYC; n++) begin
            exp_item_t it;
            it = '0;
            for (int s = 0; s < NSEED; s++) begin
                int f;
                f = first_edge(s);
                if (n >= f) it.sel[s][(n - f) % NPH] = 1'b1;
                it.lk[s] = (n >= f + NPH);
            end
            exp_q.push_back(it);
        end
    endtask

    // Check the reset state of every copy
    task automatic check_reset();
        for (int s = 0; s < NSEED; s++) begin
            n_checks++;
            if (sel_w[s] !== '0 || lk_w[s] !== 1'b0) begin
                n_fails++;
                $display("FAIL R1 seed %0d: sel=%b valid=%b expected sel=%b valid=0",
                         s, sel_w[s], lk_w[s], {NPH{1'b0}});
            end
        end
    endtask

    // Monitor: pop one expected item per cycle and compare on the falling edge
    always @(negedge clk) begin
        if (mon_en && exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            cyc_no++;
            for (int s = 0; s < NSEED; s++) begin
                // R6 before the first strobe, R3/R2 rotation after it, R5 for illegal loads
                n_checks++;
                if (sel_w[s] !== it.sel[s]) begin
                    n_fails++;
                    $display("FAIL %s seed %0d edge %0d: sel=%b expected %b",
                             (cyc_no < first_edge(s)) ? "R6" : "R3", s, cyc_no,
                             sel_w[s], it.sel[s]);
                end
                // R4: one-hot-or-zero in every cycle
                n_checks++;
                if ($countones(sel_w[s]) > 1) begin
                    n_fails++;
                    $display("FAIL R4 seed %0d edge %0d: sel=%b expected at most one bit set",
                             s, cyc_no, sel_w[s]);
                end
                // R7: valid flag timing
                n_checks++;
                if (lk_w[s] !== it.lk[s]) begin
                    n_fails++;
                    $display("FAIL R7 seed %0d edge %0d: valid=%b expected %b",
                             s, cyc_no, lk_w[s], it.lk[s]);
                end
            end
        end
    end

    // Stimulus: two reset-and-run segments; R8 reload makes them identical
    initial begin
        for (int seg = 0; seg < 2; seg++) begin
            @(negedge clk);
            rst_n = 1'b0;
            repeat (3) @(negedge clk);
            check_reset();
            rst_n = 1'b1;
            @(posedge clk);
            cyc_no = 0;
            push_run();
            mon_en = 1'b1;
            wait (exp_q.size() == 0);
            @(posedge clk);
            mon_en = 1'b0;
        end
        // R5 and R8 on the second pass: every seed, illegal ones included, followed the same schedule
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule